// File: doc/BRIEF.md
# Receive Mirror Auto-Update Scanner

This block keeps a read-only mirror of one message object up to date without any processor command. It watches three per-object status vectors: the valid bit and the new-data flag come from outside, and the auto-update enable bits are held inside the block. An object is a candidate when all three are set. When the mirror is free, the block takes the candidate with the lowest object number and fetches its five words from a synchronous message RAM port. It fills the mirror with them, clears that object's new-data flag through a one-cycle clear strobe, and then raises a request toward a DMA engine.

The request stays up until the first bus read of any mirror register, and that read is the only thing that drops it. While the request is outstanding the block does not scan, so the mirror cannot be overwritten before the DMA engine has drained it. A control input gates the request pin. The internal pending state is not gated, so with the gate closed the block still waits for a draining read. The read port only reads: the mirror offers no path that writes back into the message RAM.

Top module: `rx_mirror_scanner`

## Requirements
- R1: An object is a candidate only when its bits in `obj_valid`, `obj_newdat` and the internal enable bank are all 1. When no candidate exists, no RAM read and no request occur.
- R2: Among the candidates, the one with the lowest object number is transferred.
- R3: A transfer issues `ram_re` for five consecutive cycles, beginning the cycle after the scan. `ram_obj` stays fixed during these cycles and `ram_word` steps through 0 to 4 (mask, arbitration, control, data A, data B). `ram_rdata` must be valid one cycle after each read.
- R4: Reads with `rd_sel` = 1, 2, 3, 4 and 5 return the mask, arbitration, control, data A and data B words of the last transfer.
- R5: The cycle after the fifth read, `ndclr_vld` pulses for exactly one cycle, with `ndclr_obj` set to the transferred object.
- R6: The observation word (`rd_sel` = 0) contains a busy flag in bit 0, the pending flag in bit 1 and the transferred object number in bits 16 upward. Busy is 1 from the first read cycle through the clear cycle, and 0 otherwise.
- R7: `dma_req` rises in the cycle after the clear pulse. `dma_req` equals the pending flag ANDed with `dma_en`.
- R8: A read (`rd_en` = 1) with `rd_sel` from 0 to 5 clears the pending flag and `dma_req` at the next edge. Reads of enable halfwords do not clear them.
- R9: No RAM read starts while the pending flag is set. Scanning resumes in the cycle after the clearing read, so the first RAM read comes two cycles after it.
- R10: A write with `en_we` stores `en_wdata` into halfword `en_hw`. Bit i of halfword h enables object 16h+i. Halfword h reads back at `rd_sel` = 8+h.
- R11: After reset, all enable bits, all mirror words, busy, pending and `dma_req` are 0.
- R12: `rd_sel` values 6 and 7 read as zero, and reading them leaves `dma_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obj_valid | input | 128 | Per-object valid bits |
| obj_newdat | input | 128 | Per-object new-data flags |
| en_we | input | 1 | Enable halfword write strobe |
| en_hw | input | 3 | Enable halfword index |
| en_wdata | input | 16 | Enable halfword write data |
| dma_en | input | 1 | Gate for the request pin |
| rd_en | input | 1 | Bus read access strobe |
| rd_sel | input | 4 | Read select (0 observation, 1-5 mirror words, 8-15 enable halfwords) |
| rd_data | output | 32 | Read data, combinational on `rd_sel` |
| ram_re | output | 1 | Message RAM read enable |
| ram_obj | output | 7 | Message RAM object number |
| ram_word | output | 3 | Message RAM word within object |
| ram_rdata | input | 32 | Message RAM read data, one cycle after `ram_re` |
| ndclr_vld | output | 1 | New-data clear strobe |
| ndclr_obj | output | 7 | Object whose new-data flag is cleared |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its defaults: 128 objects in eight enable halfwords, 32-bit words, and the two-level picker with groups of 16. The two-level picker is the variant the defaults select. With these values, directed cases can reach objects 15, 16 and 127, which sit on group boundaries and at the top of the range. They also reach lower objects that lose only because their valid or enable bit is clear. Random rounds combine sparse new-data patterns, changing valid bits and rewritten enable halfwords. They also cover a closed request gate, which shows that the pending state still blocks scanning.

// File: rtl/mirror_pkg.sv
package mirror_pkg;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_READ  = 2'd1,
      XF_WBACK = 2'd2
   } xfer_state_e;

   localparam int unsigned MIRROR_WORDS = 5;
   localparam logic [2:0]  WORD_LAST    = 3'd4;
   localparam int unsigned OBS_OBJ_LSB  = 16;

endpackage

// File: rtl/mirror_en_bank.sv
module mirror_en_bank #(
   parameter int unsigned NUM_OBJ = 128,
   parameter int unsigned HW      = 16,
   parameter int unsigned HWI_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [HWI_W-1:0]   wr_hw,
   input  logic [HW-1:0]      wr_data,
   input  logic [HWI_W-1:0]   rd_hw,
   output logic [HW-1:0]      rd_data,
   output logic [NUM_OBJ-1:0] en_bits
);
   localparam int unsigned NHW = NUM_OBJ / HW;

   logic [HW-1:0]  hw_q [NHW];
   logic [NHW-1:0] hit;

   for (genvar h = 0; h < NHW; h++) begin : g_hw
      assign hit[h] = wr_en && (wr_hw == HWI_W'(h));
      assign en_bits[h*HW +: HW] = hw_q[h];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int h = 0; h < NHW; h++) hw_q[h] <= '0;
      end else begin
         for (int h = 0; h < NHW; h++)
            if (hit[h]) hw_q[h] <= wr_data;
      end
   end

   if (NHW == (1 << HWI_W)) begin : g_full
      assign rd_data = hw_q[rd_hw];
   end else begin : g_part
      always_comb begin
         rd_data = '0;
         for (int h = 0; h < NHW; h++)
            if (rd_hw == HWI_W'(h)) rd_data = hw_q[h];
      end
   end

endmodule

// File: rtl/mirror_prio_pick.sv
module mirror_prio_pick #(
   parameter int unsigned N       = 128,
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned GRP     = 16,
   parameter bit          GROUPED = 1'b1
) (
   input  logic [N-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |vec;

   if (GROUPED) begin : g_two
      localparam int unsigned NG   = N / GRP;
      localparam int unsigned GI_W = $clog2(NG);
      localparam int unsigned LI_W = $clog2(GRP);

      logic [NG-1:0]   gany;
      logic [GI_W-1:0] gsel;
      logic [GRP-1:0]  lane;
      logic [LI_W-1:0] lsel;

      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign gany[g] = |vec[g*GRP +: GRP];
      end

      always_comb begin
         gsel = '0;
         for (int g = NG - 1; g >= 0; g--)
            if (gany[g]) gsel = GI_W'(g);
      end

      assign lane = vec[gsel*GRP +: GRP];

      always_comb begin
         lsel = '0;
         for (int i = GRP - 1; i >= 0; i--)
            if (lane[i]) lsel = LI_W'(i);
      end

      assign idx = IDX_W'({gsel, lsel});
   end else begin : g_flat
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--)
            if (vec[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/mirror_regs.sv
module mirror_regs
   import mirror_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned OBJ_W = 7,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_vld,
   input  logic [2:0]       cap_word,
   input  logic [DW-1:0]    cap_data,
   input  logic             busy,
   input  logic             held,
   input  logic [OBJ_W-1:0] obj,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DW-1:0]    rd_data
);
   logic [DW-1:0] word_q [MIRROR_WORDS];
   logic [DW-1:0] obs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < MIRROR_WORDS; w++) word_q[w] <= '0;
      end else if (cap_vld) begin
         for (int w = 0; w < MIRROR_WORDS; w++)
            if (cap_word == 3'(w)) word_q[w] <= cap_data;
      end
   end

   always_comb begin
      obs                       = '0;
      obs[0]                    = busy;
      obs[1]                    = held;
      obs[OBS_OBJ_LSB +: OBJ_W] = obj;
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == '0) rd_data = obs;
      for (int w = 0; w < MIRROR_WORDS; w++)
         if (rd_idx == IDX_W'(w + 1)) rd_data = word_q[w];
   end

endmodule

// File: rtl/rx_mirror_scanner.sv
module rx_mirror_scanner
   import mirror_pkg::*;
#(
   parameter int unsigned NUM_OBJ      = 128,
   parameter int unsigned DW           = 32,
   parameter int unsigned HW           = 16,
   parameter int unsigned PICK_GRP     = 16,
   parameter bit          PICK_GROUPED = 1'b1,
   localparam int unsigned OBJ_W = $clog2(NUM_OBJ),
   localparam int unsigned NHW   = NUM_OBJ / HW,
   localparam int unsigned HWI_W = $clog2(NHW),
   localparam int unsigned IDX_W = (HWI_W > 3) ? HWI_W : 3,
   localparam int unsigned SEL_W = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OBJ-1:0] obj_valid,
   input  logic [NUM_OBJ-1:0] obj_newdat,
   input  logic               en_we,
   input  logic [HWI_W-1:0]   en_hw,
   input  logic [HW-1:0]      en_wdata,
   input  logic               dma_en,
   input  logic               rd_en,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic [DW-1:0]      rd_data,
   output logic               ram_re,
   output logic [OBJ_W-1:0]   ram_obj,
   output logic [2:0]         ram_word,
   input  logic [DW-1:0]      ram_rdata,
   output logic               ndclr_vld,
   output logic [OBJ_W-1:0]   ndclr_obj,
   output logic               dma_req
);
   if ((NUM_OBJ % HW) != 0 || NHW < 2) begin : g_bad_bank
      $error("enable bank must hold at least two whole halfwords");
   end
   if (DW < OBS_OBJ_LSB + OBJ_W || DW < HW) begin : g_bad_dw
      $error("data width too narrow for observation word or enable halfword");
   end
   if (PICK_GROUPED && ((NUM_OBJ % PICK_GRP) != 0 ||
                        (PICK_GRP & (PICK_GRP - 1)) != 0 ||
                        NUM_OBJ / PICK_GRP < 2)) begin : g_bad_grp
      $error("picker group must be a power of two dividing the object count");
   end

   xfer_state_e        st;
   logic [2:0]         wcnt;
   logic [OBJ_W-1:0]   sel_obj;
   logic               held;
   logic               cap_vld;
   logic [2:0]         cap_word;
   logic [NUM_OBJ-1:0] en_bits;
   logic [NUM_OBJ-1:0] cand;
   logic               pick_any;
   logic [OBJ_W-1:0]   pick_idx;
   logic [HW-1:0]      hw_rd;
   logic [DW-1:0]      mir_rd;
   logic               hw_ok;
   logic               clr_rd;

   mirror_en_bank #(.NUM_OBJ(NUM_OBJ), .HW(HW), .HWI_W(HWI_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (en_we),
      .wr_hw   (en_hw),
      .wr_data (en_wdata),
      .rd_hw   (rd_sel[HWI_W-1:0]),
      .rd_data (hw_rd),
      .en_bits (en_bits)
   );

   assign cand = obj_valid & obj_newdat & en_bits;

   mirror_prio_pick #(.N(NUM_OBJ), .IDX_W(OBJ_W), .GRP(PICK_GRP),
                      .GROUPED(PICK_GROUPED)) u_pick (
      .vec (cand),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign clr_rd = rd_en && !rd_sel[SEL_W-1] &&
                   (rd_sel[IDX_W-1:0] <= IDX_W'(MIRROR_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= XF_IDLE;
         wcnt     <= '0;
         sel_obj  <= '0;
         held     <= 1'b0;
         cap_vld  <= 1'b0;
         cap_word <= '0;
      end else begin
         cap_vld  <= (st == XF_READ);
         cap_word <= wcnt;
         case (st)
            XF_IDLE: begin
               if (!held && pick_any) begin
                  sel_obj <= pick_idx;
                  wcnt    <= '0;
                  st      <= XF_READ;
               end
            end
            XF_READ: begin
               wcnt <= wcnt + 3'd1;
               if (wcnt == WORD_LAST) st <= XF_WBACK;
            end
            XF_WBACK: st <= XF_IDLE;
            default:  st <= XF_IDLE;
         endcase
         if (st == XF_WBACK)  held <= 1'b1;
         else if (clr_rd)     held <= 1'b0;
      end
   end

   assign ram_re    = (st == XF_READ);
   assign ram_obj   = sel_obj;
   assign ram_word  = wcnt;
   assign ndclr_vld = (st == XF_WBACK);
   assign ndclr_obj = sel_obj;
   assign dma_req   = held && dma_en;

   mirror_regs #(.DW(DW), .OBJ_W(OBJ_W), .IDX_W(IDX_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_vld  (cap_vld),
      .cap_word (cap_word),
      .cap_data (ram_rdata),
      .busy     (st != XF_IDLE),
      .held     (held),
      .obj      (sel_obj),
      .rd_idx   (rd_sel[IDX_W-1:0]),
      .rd_data  (mir_rd)
   );

   assign hw_ok   = 32'(rd_sel[IDX_W-1:0]) < NHW;
   assign rd_data = rd_sel[SEL_W-1] ? (hw_ok ? DW'(hw_rd) : '0) : mir_rd;

endmodule

// File: rtl/mirror_scanner_chk.sv
module mirror_scanner_chk #(
   parameter int unsigned OBJ_W = 7,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned SEL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ram_re,
   input logic [OBJ_W-1:0] ram_obj,
   input logic [2:0]       ram_word,
   input logic             ndclr_vld,
   input logic [OBJ_W-1:0] ndclr_obj,
   input logic             dma_en,
   input logic             dma_req,
   input logic             rd_en,
   input logic [SEL_W-1:0] rd_sel
);
   // R3
   ram_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re && ram_word != 3'd0) |->
         ($past(ram_re) && ram_word == $past(ram_word) + 3'd1 && $stable(ram_obj)));

   // R5
   wb_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ndclr_vld |-> ($past(ram_re) && $past(ram_word) == 3'd4 && ndclr_obj == $past(ram_obj)));

   // R5
   wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ndclr_vld |=> !ndclr_vld);

   // R7
   req_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ndclr_vld) && dma_en) |-> dma_req);

   // R9
   no_scan_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> !ram_re);

   // R8
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_sel[SEL_W-1] && rd_sel[IDX_W-1:0] <= IDX_W'(5) && !ndclr_vld) |=> !dma_req);

endmodule

bind rx_mirror_scanner mirror_scanner_chk #(.OBJ_W(OBJ_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ram_re    (ram_re),
   .ram_obj   (ram_obj),
   .ram_word  (ram_word),
   .ndclr_vld (ndclr_vld),
   .ndclr_obj (ndclr_obj),
   .dma_en    (dma_en),
   .dma_req   (dma_req),
   .rd_en     (rd_en),
   .rd_sel    (rd_sel)
);

// File: tb/sim_rx_mirror_scanner.sv
`timescale 1ns/1ps
module sim_rx_mirror_scanner;
   localparam int NO = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NO-1:0] vm = '0;
   logic [NO-1:0] nd = '0;
   logic [NO-1:0] en_m = '0;
   logic          en_we = 1'b0;
   logic [2:0]    en_hw = '0;
   logic [15:0]   en_wdata = '0;
   logic          dma_en = 1'b1;
   logic          rd_en = 1'b0;
   logic [3:0]    rd_sel = '0;
   logic [31:0]   rd_data;
   logic          ram_re;
   logic [6:0]    ram_obj;
   logic [2:0]    ram_word;
   logic [31:0]   ram_rdata = '0;
   logic          ndclr_vld;
   logic [6:0]    ndclr_obj;
   logic          dma_req;

   int n_chk = 0;
   int n_bad = 0;
   int re_cnt = 0;
   int cur_obj = 0;
   bit chk_req_next = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_mirror_scanner u0 (
      .clk(clk), .rst_n(rst_n), .obj_valid(vm), .obj_newdat(nd),
      .en_we(en_we), .en_hw(en_hw), .en_wdata(en_wdata), .dma_en(dma_en),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .ram_re(ram_re), .ram_obj(ram_obj), .ram_word(ram_word), .ram_rdata(ram_rdata),
      .ndclr_vld(ndclr_vld), .ndclr_obj(ndclr_obj), .dma_req(dma_req)
   );

   function automatic logic [31:0] mem_f(input int o, input int w);
      return (32'(w + 1) << 28) ^ (32'(o) * 32'h0001_0101) ^ 32'h0BAD_F00D;
   endfunction

   function automatic logic [NO-1:0] cand();
      return vm & nd & en_m;
   endfunction

   function automatic int lowest(input logic [NO-1:0] v);
      int r = -1;
      for (int i = NO - 1; i >= 0; i--) if (v[i]) r = i;
      return r;
   endfunction

   always @(posedge clk) if (ram_re) ram_rdata <= mem_f(int'(ram_obj), int'(ram_word));

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic mon_step();
      if (!rst_n) return;
      if (chk_req_next) begin
         chk(dma_req == dma_en, "R7 request after clear", 32'(dma_req), 32'(dma_en));
         chk_req_next = 1'b0;
      end
      if (ram_re) begin
         if (dma_req) chk(1'b0, "R9 read while pending", 32'(ram_re), 32'd0);
         chk(int'(ram_word) == re_cnt, "R3 word order", 32'(ram_word), 32'(re_cnt));
         if (re_cnt == 0) begin
            chk(int'(ram_obj) == lowest(cand()), "R2 lowest wins", 32'(ram_obj), 32'(lowest(cand())));
            chk(cand()[ram_obj] == 1'b1, "R1 candidate", 32'(ram_obj), 32'(lowest(cand())));
            cur_obj = int'(ram_obj);
         end else begin
            chk(int'(ram_obj) == cur_obj, "R3 object held", 32'(ram_obj), 32'(cur_obj));
         end
         re_cnt++;
      end
      if (ndclr_vld) begin
         chk(re_cnt == 5 && int'(ndclr_obj) == cur_obj, "R5 clear strobe",
             32'(ndclr_obj), 32'(cur_obj));
         nd[ndclr_obj] = 1'b0;
         re_cnt = 0;
         chk_req_next = 1'b1;
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wr_en_hw(input int h, input logic [15:0] d);
      en_we = 1'b1; en_hw = 3'(h); en_wdata = d;
      @(negedge clk);
      en_we = 1'b0;
      en_m[h*16 +: 16] = d;
   endtask

   task automatic wait_req();
      int n = 0;
      while (!dma_req && n < 40) begin @(negedge clk); n++; end
      chk(dma_req == 1'b1, "R7 request raised", 32'(dma_req), 32'd1);
   endtask

   task automatic peek(input int o);
      rd_sel = 4'd0; #1;
      chk(rd_data[22:16] == 7'(o), "R6 observed object", 32'(rd_data[22:16]), 32'(o));
      chk(rd_data[1:0] == 2'b10, "R6 pending and idle", 32'(rd_data[1:0]), 32'd2);
      for (int w = 1; w <= 5; w++) begin
         rd_sel = 4'(w); #0.2;
         chk(rd_data == mem_f(o, w - 1), "R4 mirror word", rd_data, mem_f(o, w - 1));
      end
      rd_sel = 4'd6; #0.2;
      chk(rd_data == 32'd0, "R12 spare reads zero", rd_data, 32'd0);
      rd_sel = 4'd0;
      @(negedge clk);
   endtask

   task automatic clear_read();
      bit any;
      rd_sel = 4'($urandom_range(0, 5)); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; rd_sel = 4'd0;
      chk(dma_req == 1'b0, "R8 cleared by read", 32'(dma_req), 32'd0);
      any = |cand();
      #1;
      chk(rd_data[0] == 1'b0, "R6 busy low in scan cycle", 32'(rd_data[0]), 32'd0);
      @(negedge clk);
      chk(ram_re == any, "R9 resume after read", 32'(ram_re), 32'(any));
      chk(rd_data[0] == any, "R6 busy during read", 32'(rd_data[0]), 32'(any));
   endtask

   task automatic side_reads();
      int h = $urandom_range(0, 7);
      rd_sel = 4'(8 + h); rd_en = 1'b1; #1;
      chk(rd_data[15:0] == en_m[h*16 +: 16], "R10 enable readback",
          32'(rd_data[15:0]), 32'(en_m[h*16 +: 16]));
      @(negedge clk);
      rd_sel = 4'd7;
      chk(dma_req == 1'b1, "R8 halfword read keeps request", 32'(dma_req), 32'd1);
      @(negedge clk);
      rd_en = 1'b0; rd_sel = 4'd0;
      chk(dma_req == 1'b1, "R12 spare read keeps request", 32'(dma_req), 32'd1);
   endtask

   task automatic rand_round();
      if (|cand()) begin
         wait_req();
         peek(cur_obj);
         nd = nd | ({$urandom, $urandom, $urandom, $urandom} &
                    {$urandom, $urandom, $urandom, $urandom} &
                    {$urandom, $urandom, $urandom, $urandom});
         vm = ~({$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom});
         if ($urandom_range(0, 3) == 0)
            wr_en_hw($urandom_range(0, 7), 16'($urandom));
         if ($urandom_range(0, 2) == 0) side_reads();
         repeat (3) @(negedge clk);
         clear_read();
      end else begin
         repeat (20) @(negedge clk);
         chk(dma_req == 1'b0 && ram_re == 1'b0, "R1 nothing eligible", 32'(dma_req), 32'd0);
         nd = {$urandom, $urandom, $urandom, $urandom};
         vm = '1;
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fork
         forever begin @(negedge clk); mon_step(); end
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog", 32'd0, 32'd1);
            summary();
         end
      join_none

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(dma_req == 1'b0 && ram_re == 1'b0, "R11 no request after reset", 32'(dma_req), 32'd0);
      for (int s = 0; s < 6; s++) begin
         rd_sel = 4'(s); #0.2;
         chk(rd_data == 32'd0, "R11 mirror cleared", rd_data, 32'd0);
      end
      rd_sel = 4'd12; #0.2;
      chk(rd_data == 32'd0, "R11 enables cleared", rd_data, 32'd0);
      rd_sel = 4'd0;
      @(negedge clk);

      for (int h = 0; h < 8; h++) wr_en_hw(h, (h == 0) ? 16'hFFDF : 16'hFFFF);
      rd_sel = 4'd8; #1;
      chk(rd_data[15:0] == 16'hFFDF, "R10 halfword zero", 32'(rd_data[15:0]), 32'hFFDF);
      rd_sel = 4'd0;
      @(negedge clk);

      vm = '1; vm[3] = 1'b0;
      nd[3] = 1'b1; nd[5] = 1'b1; nd[9] = 1'b1; nd[127] = 1'b1;
      // R1: objects 3 and 5 are ineligible, 9 wins
      wait_req();
      chk(cur_obj == 9, "R1 ineligible lower objects skipped", 32'(cur_obj), 32'd9);
      peek(9);
      clear_read();
      wait_req();
      chk(cur_obj == 127, "R2 top object", 32'(cur_obj), 32'd127);
      peek(127);
      nd[17] = 1'b1; nd[16] = 1'b1; nd[15] = 1'b1;
      clear_read();
      wait_req(); peek(15); clear_read();
      wait_req(); peek(16); clear_read();
      wait_req(); peek(17);

      nd[0] = 1'b1; nd[64] = 1'b1;
      dma_en = 1'b0;
      clear_read();
      repeat (10) @(negedge clk);
      chk(dma_req == 1'b0, "R7 gated request", 32'(dma_req), 32'd0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ram_re) chk(1'b0, "R9 scan blocked while gated", 32'd1, 32'd0);
      end
      #1;
      chk(rd_data[1] == 1'b1, "R6 pending held while gated", 32'(rd_data[1]), 32'd1);
      dma_en = 1'b1; #0.2;
      chk(dma_req == 1'b1, "R7 gate reopened", 32'(dma_req), 32'd1);
      @(negedge clk);
      peek(0); clear_read();
      wait_req(); peek(64); clear_read();

      for (int r = 0; r < 60; r++) rand_round();

      repeat (10) @(negedge clk);
      summary();
   end

endmodule